// File: doc/BRIEF.md
# Packed Four-Lane Permute and Bitwise Unit

This block is one execution stage of a vector datapath. It works on 128-bit operands that hold four 32-bit lanes. Lane 0 is the least significant lane. Each cycle it can accept one operation. An operation is an opcode, an 8-bit immediate, a destination operand and a source operand, qualified by an input valid.

The unit supports the following operations:

- a lane shuffle controlled by the immediate;
- interleaving of the low or high lane pairs of the two operands;
- moving one 64-bit half of the source into the other half of the destination;
- collecting the four lane sign bits into a small integer;
- four bitwise operations.

The result is registered. It appears one cycle after the request, together with an output valid.

While no request is presented, the output register keeps its last result. This lets a downstream consumer read the result late without a stall path.

Top module: `lane_permute_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `out_valid` to 0 and `out_data` to all zeros.
- R2: `out_valid` equals `in_valid` of the previous cycle. When `in_valid` is low, `out_data` keeps its previous value whatever the other inputs carry.
- R3: Opcode 0 (shuffle) works as follows. Result lane k is picked by immediate bits [2k+1:2k], and codes 0 to 3 address lanes 0 to 3. Result lanes 0 and 1 come from `in_dst`, and result lanes 2 and 3 come from `in_src`.
- R4: Shuffling an operand with itself under immediate 0x1B reverses its lane order. Under immediate 0xAA, lane 2 is copied into all four lanes.
- R5: Opcode 1 (interleave low) yields lanes {src1, dst1, src0, dst0}, written from lane 3 down to lane 0.
- R6: Opcode 2 (interleave high) yields lanes {src3, dst3, src2, dst2}, written from lane 3 down to lane 0.
- R7: Opcode 3 (high-to-low half move) yields `in_src[127:64]` in bits 63:0 and keeps `in_dst[127:64]` in bits 127:64.
- R8: Opcode 4 (low-to-high half move) yields `in_src[63:0]` in bits 127:64 and keeps `in_dst[63:0]` in bits 63:0.
- R9: Opcode 5 (sign gather) sets result bit i to `in_src` bit 32*i+31 for i = 0 to 3. Bits 127:4 are zero.
- R10: Opcodes 6, 8 and 9 give the bitwise AND, OR and XOR of `in_dst` and `in_src`.
- R11: Opcode 7 (and-not) gives the bitwise NOT of `in_dst` ANDed with `in_src`.
- R12: Opcodes 10 to 15 give an all-zero result with `out_valid` still set. The immediate has no effect on any opcode other than 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 4 | Opcode, codes as in the requirements |
| in_imm | input | 8 | Shuffle immediate, four 2-bit lane selectors |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 128 | Registered result; sign mask occupies bits 3:0 |

## Verification
The hardest case to reach from the ports is a shuffle whose selectors point at lanes that do not collide with the intended pattern. For that case, the low and high result halves must be shown to draw from different operands. To get there, the stimulus gives every lane of both operands a distinct tagged value, so a result lane reveals both its operand and its index. Each of the 256 immediates is then swept across opcode 0. On top of this sweep, random operations run with immediates on every opcode, including the undefined codes, and with idle cycles that carry changing operands, so that the hold behaviour and the immediate's lack of effect are exercised.

// File: rtl/vpu_pkg.sv
package vpu_pkg;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int HALF_W = VEC_W / 2;
    localparam int SEL_W  = $clog2(LANES);
    localparam int IMM_W  = SEL_W * LANES;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SHUF  = 4'd0,
        OP_ILVLO = 4'd1,
        OP_ILVHI = 4'd2,
        OP_MVHL  = 4'd3,
        OP_MVLH  = 4'd4,
        OP_SGN   = 4'd5,
        OP_AND   = 4'd6,
        OP_ANDN  = 4'd7,
        OP_OR    = 4'd8,
        OP_XOR   = 4'd9
    } vpu_op_e;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        vpu_op_e          op;
        logic [IMM_W-1:0] imm;
        vec_t             dst;
        vec_t             src;
    } vpu_req_t;

    typedef struct packed {
        vec_t shuf;
        vec_t ilvlo;
        vec_t ilvhi;
        vec_t mvhl;
        vec_t mvlh;
        vec_t sgn;
        vec_t band;
        vec_t bandn;
        vec_t bor;
        vec_t bxor;
    } vpu_cand_t;

    function automatic logic op_known(logic [OP_W-1:0] code);
        return code <= OP_XOR;
    endfunction

endpackage

// File: rtl/vpu_shuffle_unpack.sv
module vpu_shuffle_unpack #(
    parameter int LW = vpu_pkg::LANE_W,
    parameter int NL = vpu_pkg::LANES
) (
    input  logic [$clog2(NL)*NL-1:0] imm,
    input  logic [LW*NL-1:0]         dst,
    input  logic [LW*NL-1:0]         src,
    output logic [LW*NL-1:0]         shuf,
    output logic [LW*NL-1:0]         ilvlo,
    output logic [LW*NL-1:0]         ilvhi
);
    localparam int SW = $clog2(NL);
    localparam int HL = NL / 2;

    logic [LW-1:0] d_l [NL];
    logic [LW-1:0] s_l [NL];

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [SW-1:0] sel;
        assign d_l[i] = dst[i*LW +: LW];
        assign s_l[i] = src[i*LW +: LW];
        assign sel    = imm[i*SW +: SW];

        // low result half draws on dst, high half on src
        if (i < HL) begin : g_lo
            assign shuf[i*LW +: LW] = d_l[sel];
        end else begin : g_hi
            assign shuf[i*LW +: LW] = s_l[sel];
        end

        // even result lanes from dst, odd from src
        if (i % 2 == 0) begin : g_even
            assign ilvlo[i*LW +: LW] = d_l[i/2];
            assign ilvhi[i*LW +: LW] = d_l[i/2 + HL];
        end else begin : g_odd
            assign ilvlo[i*LW +: LW] = s_l[i/2];
            assign ilvhi[i*LW +: LW] = s_l[i/2 + HL];
        end
    end

endmodule

// File: rtl/vpu_half_move.sv
module vpu_half_move #(
    parameter int VW = vpu_pkg::VEC_W
) (
    input  logic [VW-1:0] dst,
    input  logic [VW-1:0] src,
    output logic [VW-1:0] mvhl,
    output logic [VW-1:0] mvlh
);
    localparam int HW = VW / 2;

    // upper source half lands low, destination upper half kept
    assign mvhl = {dst[VW-1:HW], src[VW-1:HW]};
    // lower source half lands high, destination lower half kept
    assign mvlh = {src[HW-1:0], dst[HW-1:0]};

endmodule

// File: rtl/vpu_logic_sign.sv
module vpu_logic_sign #(
    parameter int LW = vpu_pkg::LANE_W,
    parameter int NL = vpu_pkg::LANES
) (
    input  logic [LW*NL-1:0] dst,
    input  logic [LW*NL-1:0] src,
    output logic [LW*NL-1:0] band,
    output logic [LW*NL-1:0] bandn,
    output logic [LW*NL-1:0] bor,
    output logic [LW*NL-1:0] bxor,
    output logic [LW*NL-1:0] sgn
);
    localparam int VW = LW * NL;

    logic [NL-1:0] mask;

    assign band  = dst & src;
    assign bandn = ~dst & src;
    assign bor   = dst | src;
    assign bxor  = dst ^ src;

    for (genvar i = 0; i < NL; i++) begin : g_sign
        assign mask[i] = src[i*LW + LW - 1];
    end

    assign sgn = {{(VW-NL){1'b0}}, mask};

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import vpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [OP_W-1:0]    in_op,
    input  logic [IMM_W-1:0]   in_imm,
    input  logic [VEC_W-1:0]   in_dst,
    input  logic [VEC_W-1:0]   in_src,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_data
);
    vpu_req_t  req;
    vpu_cand_t cand;
    vec_t      nxt;

    assign req.op  = vpu_op_e'(in_op);
    assign req.imm = in_imm;
    assign req.dst = in_dst;
    assign req.src = in_src;

    vpu_shuffle_unpack #(.LW(LANE_W), .NL(LANES)) u_perm (
        .imm   (req.imm),
        .dst   (req.dst),
        .src   (req.src),
        .shuf  (cand.shuf),
        .ilvlo (cand.ilvlo),
        .ilvhi (cand.ilvhi)
    );

    vpu_half_move #(.VW(VEC_W)) u_half (
        .dst  (req.dst),
        .src  (req.src),
        .mvhl (cand.mvhl),
        .mvlh (cand.mvlh)
    );

    vpu_logic_sign #(.LW(LANE_W), .NL(LANES)) u_bits (
        .dst   (req.dst),
        .src   (req.src),
        .band  (cand.band),
        .bandn (cand.bandn),
        .bor   (cand.bor),
        .bxor  (cand.bxor),
        .sgn   (cand.sgn)
    );

    always_comb begin
        nxt = '0;
        if (op_known(in_op)) begin
            case (req.op)
                OP_SHUF:  nxt = cand.shuf;
                OP_ILVLO: nxt = cand.ilvlo;
                OP_ILVHI: nxt = cand.ilvhi;
                OP_MVHL:  nxt = cand.mvhl;
                OP_MVLH:  nxt = cand.mvlh;
                OP_SGN:   nxt = cand.sgn;
                OP_AND:   nxt = cand.band;
                OP_ANDN:  nxt = cand.bandn;
                OP_OR:    nxt = cand.bor;
                OP_XOR:   nxt = cand.bxor;
                default:  nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= nxt;
            end
        end
    end

endmodule

// File: rtl/vpu_checker.sv
module vpu_checker
    import vpu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_op,
    input logic [VEC_W-1:0] in_dst,
    input logic [VEC_W-1:0] in_src,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_data
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    p_hl_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MVHL) |=> out_data[VEC_W-1:HALF_W] == $past(in_dst[VEC_W-1:HALF_W]));

    p_lh_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_MVLH) |=> out_data[HALF_W-1:0] == $past(in_dst[HALF_W-1:0]));

    p_sign_upper_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_SGN) |=> out_data[VEC_W-1:LANES] == '0);

    p_and_subset_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_AND) |=> (out_data & ~$past(in_src)) == '0);

    p_andn_disjoint_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_ANDN) |=> (out_data & $past(in_dst)) == '0);

    p_undef_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > OP_XOR) |=> (out_valid && out_data == '0));

endmodule

bind lane_permute_unit vpu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_dst    (in_dst),
    .in_src    (in_src),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_lane_permute_unit.sv
module sim_lane_permute_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [7:0]   in_imm = '0;
    logic [127:0] in_dst = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    logic [127:0] last_res = '0;

    always #2 clk = ~clk;

    lane_permute_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_imm(in_imm), .in_dst(in_dst), .in_src(in_src),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] ln(logic [127:0] v, int k);
        return v[k*32 +: 32];
    endfunction

    function automatic logic [127:0] model(logic [3:0] op, logic [7:0] imm,
                                           logic [127:0] d, logic [127:0] s);
        logic [127:0] r = '0;
        case (op)
            4'd0: for (int k = 0; k < 4; k++) begin
                      int sel = int'(imm[2*k +: 2]);
                      r[k*32 +: 32] = (k < 2) ? ln(d, sel) : ln(s, sel);
                  end
            4'd1: r = {ln(s,1), ln(d,1), ln(s,0), ln(d,0)};
            4'd2: r = {ln(s,3), ln(d,3), ln(s,2), ln(d,2)};
            4'd3: r = {d[127:64], s[127:64]};
            4'd4: r = {s[63:0], d[63:0]};
            4'd5: for (int k = 0; k < 4; k++) r[k] = s[32*k+31];
            4'd6: r = d & s;
            4'd7: r = ~d & s;
            4'd8: r = d | s;
            4'd9: r = d ^ s;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic issue(string req, logic [3:0] op, logic [7:0] imm,
                         logic [127:0] d, logic [127:0] s, logic [127:0] exp);
        in_valid = 1'b1; in_op = op; in_imm = imm; in_dst = d; in_src = s;
        @(negedge clk);
        check({req, " valid"}, {127'd0, out_valid}, 128'd1);
        check(req, out_data, exp);
        last_res = out_data;
    endtask

    task automatic idle(logic [127:0] d, logic [127:0] s);
        in_valid = 1'b0; in_op = 4'd9; in_imm = 8'hFF; in_dst = d; in_src = s;
        @(negedge clk);
        check("R2 idle valid", {127'd0, out_valid}, 128'd0);
        check("R2 idle hold", out_data, last_res);
    endtask

    logic [127:0] D, S;

    initial begin
        void'($urandom(32'h5EED_0042));
        // tagged lanes: dst lanes 0xD000000k, src lanes 0x5000000k
        D = {32'hD0000003, 32'hD0000002, 32'hD0000001, 32'hD0000000};
        S = {32'h50000003, 32'h50000002, 32'h50000001, 32'h50000000};
        repeat (3) @(negedge clk);
        check("R1 reset valid", {127'd0, out_valid}, 128'd0);
        check("R1 reset data", out_data, 128'd0);
        rst = 1'b0;

        issue("R3 shuffle E4", 4'd0, 8'hE4, D, S,
              {32'h50000003, 32'h50000002, 32'hD0000001, 32'hD0000000});
        issue("R3 shuffle 4E", 4'd0, 8'h4E, D, S,
              {32'h50000001, 32'h50000000, 32'hD0000003, 32'hD0000002});
        issue("R4 reverse 1B", 4'd0, 8'h1B, D, D,
              {32'hD0000000, 32'hD0000001, 32'hD0000002, 32'hD0000003});
        issue("R4 broadcast AA", 4'd0, 8'hAA, D, D, {4{32'hD0000002}});
        idle(S, D);
        issue("R5 interleave low", 4'd1, 8'h00, D, S,
              {32'h50000001, 32'hD0000001, 32'h50000000, 32'hD0000000});
        issue("R6 interleave high", 4'd2, 8'h00, D, S,
              {32'h50000003, 32'hD0000003, 32'h50000002, 32'hD0000002});
        issue("R7 high to low", 4'd3, 8'h00, D, S,
              {32'hD0000003, 32'hD0000002, 32'h50000003, 32'h50000002});
        issue("R8 low to high", 4'd4, 8'h00, D, S,
              {32'h50000001, 32'h50000000, 32'hD0000001, 32'hD0000000});
        issue("R9 sign gather", 4'd5, 8'h00, {4{32'hFFFFFFFF}},
              {32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000}, 128'hA);
        issue("R9 sign none", 4'd5, 8'hFF, {4{32'h80000000}},
              {4{32'h7FFFFFFF}}, 128'h0);
        issue("R10 and", 4'd6, 8'h00, {4{32'hF0F0FF00}}, {4{32'h3C3C0FF0}}, {4{32'h30300F00}});
        issue("R11 andnot", 4'd7, 8'h00, {4{32'hF0F0FF00}}, {4{32'h3C3C0FF0}}, {4{32'h0C0C00F0}});
        issue("R10 or", 4'd8, 8'h00, {4{32'hF0F0FF00}}, {4{32'h3C3C0FF0}}, {4{32'hFCFCFFF0}});
        issue("R10 xor", 4'd9, 8'h00, {4{32'hF0F0FF00}}, {4{32'h3C3C0FF0}}, {4{32'hCCCCF0F0}});
        issue("R12 undefined op", 4'd12, 8'h1B, D, S, 128'h0);
        issue("R12 imm ignored", 4'd1, 8'h93, D, S,
              {32'h50000001, 32'hD0000001, 32'h50000000, 32'hD0000000});
        idle(D, S);

        // exhaustive immediate sweep for the shuffle (R3)
        for (int i = 0; i < 256; i++) begin
            issue("R3 shuffle sweep", 4'd0, 8'(i), D, S, model(4'd0, 8'(i), D, S));
        end

        // random mix, including undefined opcodes and idle gaps (R2 R12)
        for (int n = 0; n < 600; n++) begin
            logic [3:0]   op = 4'($urandom());
            logic [7:0]   im = 8'($urandom());
            logic [127:0] d  = {$urandom(), $urandom(), $urandom(), $urandom()};
            logic [127:0] s  = {$urandom(), $urandom(), $urandom(), $urandom()};
            if (($urandom() % 5) == 0) idle(s, d);
            else issue("R12 random op", op, im, d, s, model(op, im, d, s));
        end

        rst = 1'b1;
        @(negedge clk);
        check("R1 reset again", {out_data[126:0], out_valid}, 128'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule